// File: doc/BRIEF.md
# Tape Controller Command Channel

This block is the command-side register file of a tape controller that serves four drives. A host writes a 16-bit command word. The block decodes the function byte, may move the unit select, and checks the command against the live state of the chosen drive. If the command fails a check, the block sets a reject bit. It never refuses the write itself.

A separate start strobe launches the stored function. An ordinary function clears the unit's latched status, raises controller busy and emits a one-cycle launch record for the operation engine. The clear function instead cancels every drive operation except a rewind in progress, wipes the controller status and the command buffer, and pulses a request to set both channel flags. When the operation engine finishes, it reports completion flags back to the block.

A status word is assembled at all times from three sources: controller-held flags, per-unit latched bits and the live drive signals.

Top module: `tape_cmd_ctrl`

## Requirements
- R1: The function is the low byte of the command word. The clear code is octal 110. Function bit 0 means motion, bit 3 means write, bit 5 means reverse, bit 6 means rewind and bit 8 means change-select.
- R2: When bit 8 of an accepted command is set, the select field in bits 12:9 maps to a drive at once, by priority. Values 0 and 1 give drive 0, 2..3 give drive 1, 4..7 give drive 2 and 8..15 give drive 3. When bit 8 is clear, the select is kept.
- R3: Every command write clears reject. A write of the clear code is always accepted, even while busy, and does not move the select.
- R4: A non-clear write while the controller is busy sets reject and leaves the unit select unchanged.
- R5: When the controller is idle, a write is rejected in three cases: it has motion and the target drive is busy, it has reverse and the target is at BOT, or it has write and the target is write-locked. Otherwise reject is cleared.
- R6: The status word layout is as follows. Bit 15 is high density and bits 14:13 are the select. Bit 11 is odd, bit 10 rewinding, bit 9 transport busy, bit 8 controller busy and bit 7 EOF. Bit 6 is BOT (live), bit 5 EOT, bit 4 timing, bit 3 reject, bit 2 write-locked, bit 1 parity and bit 0 local. Bit 12 reads 0.
- R7: For a selected drive that is not attached, status shows transport busy and local, and write-locked reads 0.
- R8: Bit 15 and bits 14:13 are driven only when the high-density parameter is set. Otherwise they read 0.
- R9: Starting the clear function pulses the flag-set output. It drives the cancel mask to every drive that has no rewind in progress. It zeroes the controller flags, reject, busy and the command buffer, and it keeps the per-unit rewind bits.
- R10: Starting any other function clears the selected unit's latched bits and sets busy. It also pulses launch with the unit and function, and asserts the short-delay flag exactly when function bit 6 is set.
- R11: A completion report clears busy. It ORs {parity, timing, EOF, odd} into the controller flags and {EOT, rewinding} into the selected unit's bits.
- R12: After reset, all registers are zero, so the status shows only the live and density bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_wdata_i | input | 16 | Command word |
| start_i | input | 1 | Launch the stored function |
| op_done_i | input | 1 | Operation completion report |
| op_flags_i | input | 4 | {parity, timing, EOF, odd} to merge |
| op_unit_flags_i | input | 2 | {EOT, rewinding} for the selected unit |
| unit_busy_i | input | 4 | Drive busy, one bit per drive |
| unit_wlock_i | input | 4 | Drive write-locked |
| unit_att_i | input | 4 | Drive attached (online) |
| unit_bot_i | input | 4 | Drive at beginning of tape |
| stat_o | output | 16 | Assembled status word |
| launch_o | output | 1 | One-cycle launch pulse |
| launch_unit_o | output | 2 | Unit being launched |
| launch_func_o | output | 8 | Function being launched |
| launch_short_o | output | 1 | Use short rewind-acknowledge delay |
| cancel_o | output | 4 | Per-drive cancel pulse on clear |
| flags_set_o | output | 1 | Pulse to set both channel flags |

## Verification
The bench builds two copies of the block that share all inputs: one with the high-density parameter on and one with it off. Comparing their status words puts both the density/select bits and their absence within reach. Four drives are kept throughout, so every branch of the priority select map can be hit, including the top 8..15 range. The drive inputs are held so that each reject cause belongs to a different drive.

// File: rtl/tape_cmd_pkg.sv
package tape_cmd_pkg;
  localparam int CMD_W  = 16;
  localparam int FUNC_W = 8;
  localparam int SEL_W  = 4;
  localparam int STAT_W = 16;

  localparam logic [FUNC_W-1:0] F_CLEAR = 8'o110;

  // command bit positions
  localparam int B_MOT   = 0;
  localparam int B_WRT   = 3;
  localparam int B_REV   = 5;
  localparam int B_RWD   = 6;
  localparam int B_CHS   = 8;
  localparam int SEL_LSB = 9;

  // status bit positions
  localparam int S_HD   = 15;
  localparam int S_SEL  = 13;
  localparam int S_ODD  = 11;
  localparam int S_REW  = 10;
  localparam int S_TBSY = 9;
  localparam int S_BUSY = 8;
  localparam int S_EOF  = 7;
  localparam int S_BOT  = 6;
  localparam int S_EOT  = 5;
  localparam int S_TIM  = 4;
  localparam int S_REJ  = 3;
  localparam int S_WLK  = 2;
  localparam int S_PAR  = 1;
  localparam int S_LOC  = 0;

  // controller flag vector index {par,tim,eof,odd}
  localparam int FL_ODD = 0;
  localparam int FL_EOF = 1;
  localparam int FL_TIM = 2;
  localparam int FL_PAR = 3;
endpackage

// File: rtl/tape_sel_map.sv
module tape_sel_map #(
  parameter int SEL_W = 4,
  parameter int UNITS = 4,
  localparam int UW = $clog2(UNITS)
) (
  input  logic [SEL_W-1:0] field_i,
  output logic [UW-1:0]    unit_o
);
  // highest set bit wins, clamped to last drive
  always_comb begin
    unit_o = '0;
    for (int i = 0; i < SEL_W; i++) begin
      if (field_i[i]) unit_o = (i < UNITS) ? UW'(i) : UW'(UNITS - 1);
    end
  end
endmodule

// File: rtl/tape_cmd_check.sv
module tape_cmd_check
  import tape_cmd_pkg::*;
(
  input  logic [FUNC_W-1:0] func_i,
  input  logic              busy_i,
  input  logic              bot_i,
  input  logic              wlock_i,
  output logic              reject_o
);
  always_comb begin
    reject_o = (func_i[B_MOT] & busy_i)
             | (func_i[B_REV] & bot_i)
             | (func_i[B_WRT] & wlock_i);
  end
endmodule

// File: rtl/tape_stat_mux.sv
module tape_stat_mux
  import tape_cmd_pkg::*;
#(
  parameter bit HIGH_DENSITY = 1'b1,
  parameter int UNITS = 4,
  localparam int UW = $clog2(UNITS)
) (
  input  logic [UW-1:0]     usel_i,
  input  logic [3:0]        flags_i,
  input  logic              busy_i,
  input  logic              rej_i,
  input  logic              rew_i,
  input  logic              eot_i,
  input  logic              att_i,
  input  logic              drv_busy_i,
  input  logic              wlock_i,
  input  logic              bot_i,
  output logic [STAT_W-1:0] stat_o
);
  always_comb begin
    stat_o = '0;
    stat_o[S_ODD]  = flags_i[FL_ODD];
    stat_o[S_EOF]  = flags_i[FL_EOF];
    stat_o[S_TIM]  = flags_i[FL_TIM];
    stat_o[S_PAR]  = flags_i[FL_PAR];
    stat_o[S_BUSY] = busy_i;
    stat_o[S_REJ]  = rej_i;
    stat_o[S_REW]  = rew_i;
    stat_o[S_EOT]  = eot_i;
    stat_o[S_BOT]  = bot_i;
    if (att_i) begin
      stat_o[S_TBSY] = drv_busy_i;
      stat_o[S_WLK]  = wlock_i;
    end else begin
      stat_o[S_TBSY] = 1'b1;
      stat_o[S_LOC]  = 1'b1;
    end
    if (HIGH_DENSITY) begin
      stat_o[S_HD]          = 1'b1;
      stat_o[S_SEL +: 2]    = 2'(usel_i);
    end
  end
endmodule

// File: rtl/tape_cmd_ctrl.sv
module tape_cmd_ctrl
  import tape_cmd_pkg::*;
#(
  parameter int UNITS = 4,
  parameter bit HIGH_DENSITY = 1'b1,
  localparam int UW = $clog2(UNITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [CMD_W-1:0]  cmd_wdata_i,
  input  logic              start_i,
  input  logic              op_done_i,
  input  logic [3:0]        op_flags_i,
  input  logic [1:0]        op_unit_flags_i,
  input  logic [UNITS-1:0]  unit_busy_i,
  input  logic [UNITS-1:0]  unit_wlock_i,
  input  logic [UNITS-1:0]  unit_att_i,
  input  logic [UNITS-1:0]  unit_bot_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              launch_o,
  output logic [UW-1:0]     launch_unit_o,
  output logic [FUNC_W-1:0] launch_func_o,
  output logic              launch_short_o,
  output logic [UNITS-1:0]  cancel_o,
  output logic              flags_set_o
);
  logic [FUNC_W-1:0] cmd_q;
  logic [UW-1:0]     usel_q;
  logic              busy_q, rej_q;
  logic [3:0]        flags_q;
  logic [UNITS-1:0]  unit_rew_q, unit_eot_q;

  logic [FUNC_W-1:0] wr_func;
  logic              wr_clear, wr_chs, st_clear, chk_rej;
  logic [UW-1:0]     map_unit, tgt_unit;

  assign wr_func  = cmd_wdata_i[FUNC_W-1:0];
  assign wr_clear = (wr_func == F_CLEAR);
  assign wr_chs   = cmd_wdata_i[B_CHS];
  assign st_clear = (cmd_q == F_CLEAR);
  assign tgt_unit = wr_chs ? map_unit : usel_q;

  tape_sel_map #(.SEL_W(SEL_W), .UNITS(UNITS)) u_sel_map (
    .field_i (cmd_wdata_i[SEL_LSB +: SEL_W]),
    .unit_o  (map_unit)
  );

  tape_cmd_check u_check (
    .func_i   (wr_func),
    .busy_i   (unit_busy_i[tgt_unit]),
    .bot_i    (unit_bot_i[tgt_unit]),
    .wlock_i  (unit_wlock_i[tgt_unit]),
    .reject_o (chk_rej)
  );

  tape_stat_mux #(.HIGH_DENSITY(HIGH_DENSITY), .UNITS(UNITS)) u_stat (
    .usel_i     (usel_q),
    .flags_i    (flags_q),
    .busy_i     (busy_q),
    .rej_i      (rej_q),
    .rew_i      (unit_rew_q[usel_q]),
    .eot_i      (unit_eot_q[usel_q]),
    .att_i      (unit_att_i[usel_q]),
    .drv_busy_i (unit_busy_i[usel_q]),
    .wlock_i    (unit_wlock_i[usel_q]),
    .bot_i      (unit_bot_i[usel_q]),
    .stat_o     (stat_o)
  );

  // start has priority over a write, a write over a completion report
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q          <= '0;
      usel_q         <= '0;
      busy_q         <= 1'b0;
      rej_q          <= 1'b0;
      flags_q        <= '0;
      unit_rew_q     <= '0;
      unit_eot_q     <= '0;
      launch_o       <= 1'b0;
      launch_unit_o  <= '0;
      launch_func_o  <= '0;
      launch_short_o <= 1'b0;
      cancel_o       <= '0;
      flags_set_o    <= 1'b0;
    end else begin
      launch_o    <= 1'b0;
      cancel_o    <= '0;
      flags_set_o <= 1'b0;
      if (start_i) begin
        if (st_clear) begin
          flags_q     <= '0;
          rej_q       <= 1'b0;
          busy_q      <= 1'b0;
          cmd_q       <= '0;
          cancel_o    <= ~unit_rew_q;
          flags_set_o <= 1'b1;
        end else begin
          unit_rew_q[usel_q] <= 1'b0;
          unit_eot_q[usel_q] <= 1'b0;
          busy_q         <= 1'b1;
          launch_o       <= 1'b1;
          launch_unit_o  <= usel_q;
          launch_func_o  <= cmd_q;
          launch_short_o <= cmd_q[B_RWD];
        end
      end else if (cmd_we_i) begin
        cmd_q <= wr_func;
        rej_q <= 1'b0;
        if (!wr_clear) begin
          if (busy_q) begin
            rej_q <= 1'b1;
          end else begin
            if (wr_chs) usel_q <= map_unit;
            rej_q <= chk_rej;
          end
        end
      end else if (op_done_i) begin
        busy_q  <= 1'b0;
        flags_q <= flags_q | op_flags_i;
        unit_rew_q[usel_q] <= unit_rew_q[usel_q] | op_unit_flags_i[0];
        unit_eot_q[usel_q] <= unit_eot_q[usel_q] | op_unit_flags_i[1];
      end
    end
  end

  p_clear_write_ok_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && !start_i && wr_clear) |=> !stat_o[S_REJ]);

  p_busy_reject_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && !start_i && !wr_clear && busy_q) |=> (stat_o[S_REJ] && $stable(usel_q)));

  p_start_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !st_clear) |=> (stat_o[S_BUSY] && launch_o));

  p_clear_cancel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && st_clear) |=> (flags_set_o && !stat_o[S_BUSY] && (cancel_o == ~$past(unit_rew_q))));

  p_offline_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unit_att_i[usel_q] |-> (stat_o[S_TBSY] && stat_o[S_LOC] && !stat_o[S_WLK]));

  p_done_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_done_i && !start_i && !cmd_we_i) |=> !stat_o[S_BUSY]);
endmodule

// File: tb/tape_cmd_ctrl_bench.sv
module tape_cmd_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [15:0] cmd_wdata = '0;
  logic        start = 1'b0;
  logic        op_done = 1'b0;
  logic [3:0]  op_flags = '0;
  logic [1:0]  op_uflags = '0;
  logic [3:0]  u_busy = 4'b0010, u_wl = 4'b0100, u_att = 4'b1111, u_bot = 4'b1000;

  logic [15:0] stat_hi, stat_lo;
  logic        launch, launch_lo;
  logic [1:0]  l_unit, l_unit_lo;
  logic [7:0]  l_func, l_func_lo;
  logic        l_short, l_short_lo;
  logic [3:0]  cancel, cancel_lo;
  logic        fset, fset_lo;

  int checks = 0;
  int fails  = 0;
  bit done_run = 1'b0;

  always #4 clk = ~clk;

  tape_cmd_ctrl #(.UNITS(4), .HIGH_DENSITY(1'b1)) u_tape_cmd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wdata),
    .start_i(start), .op_done_i(op_done), .op_flags_i(op_flags),
    .op_unit_flags_i(op_uflags), .unit_busy_i(u_busy), .unit_wlock_i(u_wl),
    .unit_att_i(u_att), .unit_bot_i(u_bot), .stat_o(stat_hi), .launch_o(launch),
    .launch_unit_o(l_unit), .launch_func_o(l_func), .launch_short_o(l_short),
    .cancel_o(cancel), .flags_set_o(fset));

  tape_cmd_ctrl #(.UNITS(4), .HIGH_DENSITY(1'b0)) u_low (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wdata),
    .start_i(start), .op_done_i(op_done), .op_flags_i(op_flags),
    .op_unit_flags_i(op_uflags), .unit_busy_i(u_busy), .unit_wlock_i(u_wl),
    .unit_att_i(u_att), .unit_bot_i(u_bot), .stat_o(stat_lo), .launch_o(launch_lo),
    .launch_unit_o(l_unit_lo), .launch_func_o(l_func_lo), .launch_short_o(l_short_lo),
    .cancel_o(cancel_lo), .flags_set_o(fset_lo));

  // {command word, expected reject, expected unit}
  localparam logic [18:0] VECS [11] = '{
    {16'h0313, 1'b0, 2'd0},   // sel 1 -> 0, read
    {16'h0513, 1'b1, 2'd1},   // sel 2 -> 1, read on busy drive
    {16'h070D, 1'b1, 2'd1},   // sel 3 -> 1, gap has motion
    {16'h0919, 1'b1, 2'd2},   // sel 4 -> 2, write on locked drive
    {16'h0F03, 1'b0, 2'd2},   // sel 7 -> 2, space forward
    {16'h1121, 1'b1, 2'd3},   // sel 8 -> 3, reverse at BOT
    {16'h1F03, 1'b0, 2'd3},   // sel 15 -> 3, forward
    {16'h01A1, 1'b0, 2'd0},   // sel 0 -> 0, backward file
    {16'h1021, 1'b0, 2'd0},   // no change-select: stays 0
    {16'h1341, 1'b0, 2'd3},   // sel 9 -> 3, rewind has no reverse
    {16'h0589, 1'b1, 2'd1}    // sel 2 -> 1, file mark: motion+write
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] w);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = w;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic go();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic fin(input logic [3:0] f, input logic [1:0] u);
    @(negedge clk); op_done = 1'b1; op_flags = f; op_uflags = u;
    @(negedge clk); op_done = 1'b0; op_flags = '0; op_uflags = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_run) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 status hi", stat_hi, 32'h8000);
    chk("R12 status lo", stat_lo, 32'h0000);
    chk("R12 outputs", {launch, cancel, fset}, 0);

    // R1 R2 R5 table
    for (int i = 0; i < 11; i++) begin
      wr(VECS[i][18:3]);
      chk("R2 select", stat_hi[14:13], VECS[i][1:0]);
      chk("R5 R1 reject", stat_hi[3], VECS[i][2]);
      chk("R8 low density bits", stat_lo[15:13], 0);
    end

    // R6 layout
    wr(16'h0900);
    chk("R6 unit2 wlock", stat_hi, 32'hC004);
    wr(16'h0500);
    chk("R6 unit1 transport busy", stat_hi, 32'hA200);
    wr(16'h1100);
    chk("R6 unit3 bot", stat_hi, 32'hE040);
    chk("R8 low unit3", stat_lo, 32'h0040);

    // R7 offline drive
    @(negedge clk); u_att = 4'b0111; u_wl = 4'b1100;
    @(negedge clk);
    chk("R7 offline", stat_hi, 32'hE241);
    u_att = 4'b1111; u_wl = 4'b0100;

    // R10 launch a read on drive 0
    wr(16'h0113);
    chk("R5 read accepted", stat_hi[3], 0);
    go();
    chk("R10 launch", {launch, l_unit, l_func, l_short}, {1'b1, 2'd0, 8'h13, 1'b0});
    chk("R10 busy", stat_hi[8], 1);
    @(negedge clk);
    chk("R10 single pulse", launch, 0);

    // R4 busy reject, select held
    wr(16'h0513);
    chk("R4 reject", stat_hi[3], 1);
    chk("R4 select held", stat_hi[14:13], 0);
    // R3 clear write while busy
    wr(16'h0048);
    chk("R3 clear accepted", stat_hi[3], 0);

    // R11 completion
    fin(4'b0011, 2'b10);
    chk("R11 merge", stat_hi, 32'h88A0);

    // R10 rewind: short delay, unit bits cleared
    wr(16'h0041);
    go();
    chk("R10 short delay", {launch, l_func, l_short}, {1'b1, 8'h41, 1'b1});
    chk("R10 unit status cleared", stat_hi, 32'h8980);
    fin(4'b0000, 2'b01);
    chk("R11 rewinding", stat_hi, 32'h8C80);

    // R9 clear start
    wr(16'h0048);
    go();
    chk("R9 cancel mask", cancel, 4'b1110);
    chk("R9 flag set", fset, 1);
    chk("R9 status zeroed", stat_hi, 32'h8400);
    @(negedge clk);
    chk("R9 pulse ends", {cancel, fset}, 0);
    go();
    chk("R9 buffer zeroed", {launch, l_func}, {1'b1, 8'h00});
    chk("R10 rewind bit cleared", stat_hi[10], 0);

    done_run = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule